// File: doc/BRIEF.md
# Transmit descriptor ring DMA engine

This block walks a ring of transmit descriptors kept in system memory and turns each referenced buffer into a byte stream for a downstream frame transmitter. Software fills in descriptors, sets the ownership flag in each one, and programs a ring base address. It then raises the run control. The engine reads each descriptor and checks that it owns it. It streams the buffer bytes with first/last segment markers. When the buffer is done, it writes the control word back with ownership cleared, which returns the descriptor to software. It then moves to the next descriptor.

When the engine meets a descriptor it does not own, it parks in a suspended state. A one-cycle poll request makes it read the same descriptor again. Dropping the run control lets the descriptor in progress finish, and the engine then goes idle. A 3-bit process-state code reports the engine's activity at all times. An optional interrupt pulse is raised after a descriptor's write-back.

The engine has ten internal states, and each one maps to a process-state code:

| State | Code | Activity |
|---|---|---|
| S_IDLE | 000 | Stopped. |
| S_FETCH0 to S_FETCH3 | 001 | Reading descriptor words 0 to 3. |
| S_ADVANCE | 001 | Selecting the next descriptor address. |
| S_LOAD | 011 | Reading one buffer word. |
| S_EMIT | 011 | Handing out that word's bytes. |
| S_CLOSE | 010 | Status write-back. |
| S_HALT | 110 | Suspended. |

The transitions are:
- IDLE→FETCH0 when run is high; the current address loads from the base.
- FETCH0→HALT when the ownership bit is 0; otherwise FETCH0→FETCH1→FETCH2→FETCH3, each on a memory acknowledge.
- FETCH3→LOAD when the length is non-zero, or FETCH3→CLOSE when it is zero.
- LOAD→EMIT on acknowledge.
- EMIT→LOAD when a word is used up; EMIT→CLOSE after the final byte.
- CLOSE→ADVANCE on acknowledge.
- ADVANCE→FETCH0 when run is high, or ADVANCE→IDLE when it is low.
- HALT→FETCH0 on a poll request; HALT→IDLE when run is low.

Top module: `txring_dma`

## Requirements
- R1: After reset the process state is 000, and `mem_req`, `tx_valid` and `irq` are low.
- R2: With `cfg_run` high in the stopped state, the next memory request is a read of the word at `cfg_base`, and the process state reads 001 while descriptor words are read.
- R3: A descriptor occupies four 32-bit words at ascending addresses A, A+4, A+8 and A+12. Word 0 is control/status. Word 1 carries the byte count in bits 11:0, and its upper bits are ignored. Word 2 is the buffer address, taken word aligned. Word 3 is the link address. A memory request holds its address, data and direction until `mem_ack`.
- R4: A descriptor whose word 0 bit 31 is 0 is not processed. The engine shows 110, issues no memory request and sends no byte until `poll_req`, which re-reads the same descriptor address.
- R5: Buffer bytes leave in ascending address order, byte 0 of each word from bits 7:0. Exactly the byte count is sent. A byte is taken when `tx_valid` and `tx_ready` are both high, and data and markers stay steady while `tx_ready` is low.
- R6: `tx_first` is high on the first byte only if word 0 bit 28 is set. `tx_last` is high on the final byte only if word 0 bit 29 is set.
- R7: After the final byte, word 0 is written back to the descriptor address with bit 31 and bit 15 cleared and every other bit unchanged. The process state reads 010 during this write.
- R8: If word 0 bit 30 is set, `irq` is high for exactly one cycle, the cycle after the write-back is acknowledged.
- R9: The next descriptor address is `cfg_base` if word 0 bit 21 is set. Otherwise it is word 3 if bit 20 is set. Otherwise it is the current address plus 16. Bit 21 wins over bit 20.
- R10: A descriptor with a byte count of 0 sends no byte but is still written back and released.
- R11: With `cfg_run` low, the engine finishes the descriptor in progress and then returns to 000 without reading the next one. From the suspended state it returns to 000 directly.
- R12: The process state only ever reads 000, 001, 010, 011 or 110. A byte is offered only under 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Ring base address |
| cfg_run | input | 1 | Run control (level) |
| poll_req | input | 1 | One-cycle request to re-read a suspended descriptor |
| proc_state | output | 3 | Encoded process state |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| irq | output | 1 | Completion pulse |

## Verification
On every cycle, the bound checker holds the following:
- the process-state code stays legal;
- a memory request holds steady until acknowledged;
- a byte is held under back-pressure;
- the write-back coincides with the 010 code;
- the suspended and stopped states stay quiet;
- an interrupt pulse only follows an acknowledged write.

Only the bench scenarios can show the data-dependent parts: byte order and count, marker placement, and the written-back control word. They also show the choice among wrap, link and sequential next addresses. The last two, the stop-after-current behaviour and resumption of the same descriptor on a poll, depend on memory contents.

// File: rtl/txring_pkg.sv
package txring_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH0,
        S_FETCH1,
        S_FETCH2,
        S_FETCH3,
        S_LOAD,
        S_EMIT,
        S_CLOSE,
        S_ADVANCE,
        S_HALT
    } tx_state_e;

    // control word bit positions (fixed by the descriptor layout)
    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned IRQ_BIT   = 30;
    localparam int unsigned LAST_BIT  = 29;
    localparam int unsigned FIRST_BIT = 28;
    localparam int unsigned WRAP_BIT  = 21;
    localparam int unsigned LINK_BIT  = 20;
    localparam int unsigned ERR_BIT   = 15;

    localparam logic [2:0] PS_STOP  = 3'b000;
    localparam logic [2:0] PS_FETCH = 3'b001;
    localparam logic [2:0] PS_WAIT  = 3'b010;
    localparam logic [2:0] PS_READ  = 3'b011;
    localparam logic [2:0] PS_SUSP  = 3'b110;

    function automatic logic [2:0] state_code(input tx_state_e s);
        logic [2:0] c;
        case (s)
            S_FETCH0, S_FETCH1, S_FETCH2,
            S_FETCH3, S_ADVANCE:          c = PS_FETCH;
            S_LOAD, S_EMIT:               c = PS_READ;
            S_CLOSE:                      c = PS_WAIT;
            S_HALT:                       c = PS_SUSP;
            default:                      c = PS_STOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/txring_nextaddr.sv
module txring_nextaddr #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] link_i,
    input  logic          wrap_i,
    input  logic          chain_i,
    output logic [AW-1:0] next_o
);
    localparam int DESC_BYTES = 4 * (DW / 8);

    // wrap has priority over chaining; otherwise descriptors are contiguous
    always_comb begin
        if (wrap_i)
            next_o = base_i;
        else if (chain_i)
            next_o = link_i;
        else
            next_o = cur_i + AW'(DESC_BYTES);
    end
endmodule

// File: rtl/txring_bytesel.sv
module txring_bytesel #(
    parameter int DW = 32,
    localparam int LANES = DW / 8,
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DW-1:0]   word_i,
    input  logic [SELW-1:0] idx_i,
    output logic [7:0]      byte_o
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
    end

    assign byte_o = lane[idx_i];
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
    import txring_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LEN_W = 12,
    localparam int LANES = DW / 8,
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cfg_base,
    input  logic            cfg_run,
    input  logic            poll_req,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            tx_ready,
    input  logic [AW-1:0]   next_addr_i,
    output tx_state_e       state_o,
    output logic [AW-1:0]   cur_addr_o,
    output logic [DW-1:0]   ctrl_o,
    output logic [AW-1:0]   link_o,
    output logic [DW-1:0]   word_o,
    output logic [SELW-1:0] lane_o,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            tx_valid,
    output logic            tx_first,
    output logic            tx_last,
    output logic            irq
);
    localparam int STEP = DW / 8;
    localparam logic [SELW-1:0] LAST_LANE = SELW'(LANES - 1);
    localparam logic [DW-1:0] CLR_MASK = (DW'(1) << OWN_BIT) | (DW'(1) << ERR_BIT);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(STEP - 1);

    tx_state_e         state, nstate;
    logic [AW-1:0]     cur_q;
    logic [DW-1:0]     ctrl_q;
    logic [LEN_W-1:0]  len_q;
    logic [AW-1:0]     buf_q;
    logic [AW-1:0]     link_q;
    logic [DW-1:0]     word_q;
    logic [SELW-1:0]   lane_q;
    logic [LEN_W-1:0]  remain_q;
    logic              first_q;
    logic              irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:    if (cfg_run) nstate = S_FETCH0;
            S_FETCH0:  if (mem_ack) nstate = mem_rdata[OWN_BIT] ? S_FETCH1 : S_HALT;
            S_FETCH1:  if (mem_ack) nstate = S_FETCH2;
            S_FETCH2:  if (mem_ack) nstate = S_FETCH3;
            S_FETCH3:  if (mem_ack) nstate = (len_q == '0) ? S_CLOSE : S_LOAD;
            S_LOAD:    if (mem_ack) nstate = S_EMIT;
            S_EMIT: begin
                if (tx_ready) begin
                    if (remain_q == LEN_W'(1))
                        nstate = S_CLOSE;
                    else if (lane_q == LAST_LANE)
                        nstate = S_LOAD;
                end
            end
            S_CLOSE:   if (mem_ack) nstate = S_ADVANCE;
            S_ADVANCE: nstate = cfg_run ? S_FETCH0 : S_IDLE;
            S_HALT: begin
                if (!cfg_run)
                    nstate = S_IDLE;
                else if (poll_req)
                    nstate = S_FETCH0;
            end
            default:   nstate = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_FETCH0: begin mem_req = 1'b1; mem_addr = cur_q; end
            S_FETCH1: begin mem_req = 1'b1; mem_addr = cur_q + AW'(STEP); end
            S_FETCH2: begin mem_req = 1'b1; mem_addr = cur_q + AW'(2 * STEP); end
            S_FETCH3: begin mem_req = 1'b1; mem_addr = cur_q + AW'(3 * STEP); end
            S_LOAD:   begin mem_req = 1'b1; mem_addr = buf_q; end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = ctrl_q & ~CLR_MASK;
            end
            default: ;
        endcase
        tx_valid = (state == S_EMIT);
        tx_first = tx_valid && first_q && ctrl_q[FIRST_BIT];
        tx_last  = tx_valid && (remain_q == LEN_W'(1)) && ctrl_q[LAST_BIT];
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            ctrl_q   <= '0;
            len_q    <= '0;
            buf_q    <= '0;
            link_q   <= '0;
            word_q   <= '0;
            lane_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                S_IDLE:   if (cfg_run) cur_q <= cfg_base;
                S_FETCH0: if (mem_ack) ctrl_q <= mem_rdata;
                S_FETCH1: if (mem_ack) len_q <= mem_rdata[LEN_W-1:0];
                S_FETCH2: if (mem_ack) buf_q <= mem_rdata[AW-1:0] & ALIGN_MASK;
                S_FETCH3: begin
                    if (mem_ack) begin
                        link_q   <= mem_rdata[AW-1:0];
                        remain_q <= len_q;
                        first_q  <= 1'b1;
                    end
                end
                S_LOAD: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        lane_q <= '0;
                        buf_q  <= buf_q + AW'(STEP);
                    end
                end
                S_EMIT: begin
                    if (tx_ready) begin
                        remain_q <= remain_q - 1'b1;
                        first_q  <= 1'b0;
                        lane_q   <= lane_q + 1'b1;
                    end
                end
                S_CLOSE:   if (mem_ack) irq_q <= ctrl_q[IRQ_BIT];
                S_ADVANCE: cur_q <= next_addr_i;
                default: ;
            endcase
        end
    end

    assign state_o    = state;
    assign cur_addr_o = cur_q;
    assign ctrl_o     = ctrl_q;
    assign link_o     = link_q;
    assign word_o     = word_q;
    assign lane_o     = lane_q;
    assign irq        = irq_q;
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LEN_W = 12,
    localparam int LANES = DW / 8,
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic          cfg_run,
    input  logic          poll_req,
    output logic [2:0]    proc_state,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_first,
    output logic          tx_last,
    output logic          irq
);
    tx_state_e       state;
    logic [AW-1:0]   cur_addr;
    logic [DW-1:0]   ctrl_w;
    logic [AW-1:0]   link_ptr;
    logic [DW-1:0]   word_w;
    logic [SELW-1:0] lane_w;
    logic [AW-1:0]   next_addr;

    txring_ctrl #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .cfg_run    (cfg_run),
        .poll_req   (poll_req),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .tx_ready   (tx_ready),
        .next_addr_i(next_addr),
        .state_o    (state),
        .cur_addr_o (cur_addr),
        .ctrl_o     (ctrl_w),
        .link_o     (link_ptr),
        .word_o     (word_w),
        .lane_o     (lane_w),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .tx_valid   (tx_valid),
        .tx_first   (tx_first),
        .tx_last    (tx_last),
        .irq        (irq)
    );

    txring_nextaddr #(.AW(AW), .DW(DW)) u_next (
        .cur_i  (cur_addr),
        .base_i (cfg_base),
        .link_i (link_ptr),
        .wrap_i (ctrl_w[WRAP_BIT]),
        .chain_i(ctrl_w[LINK_BIT]),
        .next_o (next_addr)
    );

    txring_bytesel #(.DW(DW)) u_bytes (
        .word_i(word_w),
        .idx_i (lane_w),
        .byte_o(tx_data)
    );

    assign proc_state = state_code(state);
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    proc_state,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_first,
    input logic          tx_last,
    input logic          irq
);
    // R12: only the defined codes appear
    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        proc_state inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110});

    // R12: bytes are offered only while reading buffer data
    a_r12_valid_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> proc_state == 3'b011);

    // R3: a pending request keeps its address, data and direction
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R5: byte and markers held under back-pressure
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

    // R7: status code 010 always comes with a write request
    a_r7_wait_writes: assert property (@(posedge clk) disable iff (!rst_n)
        proc_state == 3'b010 |-> mem_req && mem_we);

    // R8: interrupt only right after an acknowledged write
    a_r8_irq_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_ack));

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: suspended engine is silent
    a_r4_susp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        proc_state == 3'b110 |-> !mem_req && !tx_valid);

    // R11: stopped engine is silent
    a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        proc_state == 3'b000 |-> !mem_req && !tx_valid);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .proc_state(proc_state),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_first  (tx_first),
    .tx_last   (tx_last),
    .irq       (irq)
);

// File: tb/txring_dma_tb.sv
module txring_dma_tb;
    // one time unit is taken as 1 ns: 20-unit period, 50 MHz
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [31:0] cfg_base;
    logic        cfg_run;
    logic        poll_req;
    logic [2:0]  proc_state;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, tx_first, tx_last, irq;
    logic [7:0]  tx_data;

    txring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_run(cfg_run),
        .poll_req(poll_req), .proc_state(proc_state),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .irq(irq)
    );

    localparam logic [31:0] OWN = 32'h8000_0000, IRQB = 32'h4000_0000,
                            LSEG = 32'h2000_0000, FSEG = 32'h1000_0000,
                            WRAP = 32'h0020_0000, LINK = 32'h0010_0000,
                            ERRB = 32'h0000_8000;

    int total = 0, bad = 0;
    int bytes_seen = 0, irq_seen = 0, code_err = 0, rdy_cnt = 0;
    bit stall_mode = 0, done = 0;
    logic [9:0] expq [$];
    logic [9:0] exp_item;
    logic [2:0] exp_code;
    logic [31:0] mem [0:511];

    // memory model: one-cycle acknowledge, then a gap cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // downstream readiness
    initial begin
        tx_ready = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            rdy_cnt++;
            tx_ready = stall_mode ? (rdy_cnt % 3 != 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (mem_req) begin
                exp_code = mem_we ? 3'b010 : ((mem_addr >= 32'h400) ? 3'b011 : 3'b001);
                if (proc_state !== exp_code) code_err++;
            end
            if (tx_valid && proc_state !== 3'b011) code_err++;
            if (tx_valid && tx_ready) begin
                bytes_seen++;
                total++;
                if (expq.size() == 0) begin
                    bad++;
                    $display("FAIL R5: unexpected byte actual=%h expected=none", {tx_first, tx_last, tx_data});
                end else begin
                    exp_item = expq.pop_front();
                    if ({tx_first, tx_last, tx_data} !== exp_item) begin
                        bad++;
                        $display("FAIL R5/R6: actual=%h expected=%h", {tx_first, tx_last, tx_data}, exp_item);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3: write a descriptor (4 words) and its buffer; optionally queue expected bytes
    task automatic put_desc(input logic [31:0] a, input logic [31:0] ctrl, input logic [31:0] w1,
                            input logic [31:0] bufa, input logic [31:0] nxt,
                            input logic [7:0] seed, input bit expect_it);
        int n;
        logic [7:0] b;
        logic [31:0] ba;
        mem[a[10:2]]       = ctrl;
        mem[a[10:2] + 1]   = w1;
        mem[a[10:2] + 2]   = bufa;
        mem[a[10:2] + 3]   = nxt;
        n = int'(w1[11:0]);
        for (int i = 0; i < n; i++) begin
            b  = seed + 8'(i * 3);
            ba = bufa + 32'(i);
            mem[ba[10:2]][8*ba[1:0] +: 8] = b;
            if (expect_it)
                expq.push_back({(i == 0) && ctrl[28], (i == n - 1) && ctrl[29], b});
        end
    endtask

    task automatic wait_code(input logic [2:0] c, input string req);
        int n = 0;
        while (proc_state !== c && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(proc_state === c, req, 32'(proc_state), 32'(c));
    endtask

    task automatic poll();
        @(negedge clk) poll_req = 1'b1;
        @(negedge clk) poll_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int b0, i0, n;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        rst_n = 1'b0; cfg_base = 32'h100; cfg_run = 1'b0; poll_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(proc_state == 3'b000, "R1 state", 32'(proc_state), 0);
        chk(!mem_req && !tx_valid, "R1 req/valid", {mem_req, tx_valid}, 0);
        chk(!irq, "R1 irq", 32'(irq), 0);

        // sequential ring of three, last wraps; one with error bit preset
        put_desc(32'h100, OWN | FSEG | IRQB,        32'hABCD_0005, 32'h400, 32'h0, 8'h10, 1);
        put_desc(32'h110, OWN | ERRB,               32'h0000_0008, 32'h500, 32'h0, 8'h40, 1);
        put_desc(32'h120, OWN | LSEG | IRQB | WRAP, 32'h0000_0001, 32'h600, 32'h0, 8'h70, 1);
        cfg_run = 1'b1;
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == 32'h100, "R2 first fetch address", mem_addr, 32'h100);
        chk(proc_state == 3'b001, "R2 fetch code", 32'(proc_state), 1);
        wait_code(3'b110, "R4 suspend after wrap");
        chk(expq.size() == 0, "R5 all bytes sent", expq.size(), 0);
        chk(mem[32'h100 >> 2] == (FSEG | IRQB), "R7 writeback d0", mem[32'h100 >> 2], FSEG | IRQB);
        chk(mem[32'h110 >> 2] == 32'h0, "R7 writeback clears error", mem[32'h110 >> 2], 0);
        chk(mem[32'h120 >> 2] == (LSEG | IRQB | WRAP), "R7 writeback d2", mem[32'h120 >> 2], LSEG | IRQB | WRAP);
        chk(irq_seen == 2, "R8 irq count", irq_seen, 2);
        b0 = bytes_seen;
        repeat (20) @(negedge clk);
        chk(proc_state == 3'b110 && bytes_seen == b0, "R4 stays suspended", 32'(proc_state), 32'h6);

        // R4/R9: re-arm base descriptor; poll must re-read it (wrap returned to base)
        put_desc(32'h100, OWN | FSEG | LSEG | WRAP, 32'h0000_0003, 32'h480, 32'h0, 8'hA0, 1);
        poll();
        wait_code(3'b110, "R4 suspend after poll");
        chk(expq.size() == 0, "R4 poll resumed same descriptor", expq.size(), 0);

        // chained walk with back-pressure, zero length, wrap beating link
        stall_mode = 1;
        i0 = irq_seen;
        put_desc(32'h100, OWN | FSEG | LINK,               32'h0000_0006, 32'h700, 32'h200, 8'h21, 1);
        put_desc(32'h200, OWN | LINK | IRQB,               32'h0000_0000, 32'h740, 32'h300, 8'h00, 1);
        put_desc(32'h300, OWN | LSEG | WRAP | LINK | IRQB, 32'h0000_0004, 32'h780, 32'h340, 8'h55, 1);
        put_desc(32'h340, OWN | FSEG | LSEG,               32'h0000_0002, 32'h7C0, 32'h0,   8'hEE, 0);
        poll();
        wait_code(3'b110, "R9 chain walk ends suspended");
        chk(expq.size() == 0, "R9 chained bytes sent", expq.size(), 0);
        chk(mem[32'h200 >> 2] == (LINK | IRQB), "R10 zero length released", mem[32'h200 >> 2], LINK | IRQB);
        chk(mem[32'h340 >> 2][31] == 1'b1, "R9 wrap beats link", mem[32'h340 >> 2], OWN);
        chk(irq_seen - i0 == 2, "R8 irq count chained", irq_seen - i0, 2);
        stall_mode = 0;

        // R11: stop during a descriptor
        put_desc(32'h100, OWN | FSEG | LSEG, 32'h0000_0004, 32'h400, 32'h0, 8'h33, 1);
        put_desc(32'h110, OWN | FSEG | LSEG, 32'h0000_0004, 32'h500, 32'h0, 8'h99, 0);
        b0 = bytes_seen;
        poll();
        n = 0;
        while (bytes_seen == b0 && n < 2000) begin @(negedge clk); n++; end
        cfg_run = 1'b0;
        wait_code(3'b000, "R11 stop after current");
        chk(expq.size() == 0, "R11 current finished", expq.size(), 0);
        chk(mem[32'h110 >> 2][31] == 1'b1, "R11 next not taken", mem[32'h110 >> 2], OWN);

        // R2/R11: restart at base (not owned) then stop from suspend
        cfg_run = 1'b1;
        @(negedge clk);
        chk(mem_req && mem_addr == 32'h100, "R2 restart at base", mem_addr, 32'h100);
        wait_code(3'b110, "R4 base not owned");
        cfg_run = 1'b0;
        wait_code(3'b000, "R11 stop from suspend");

        chk(code_err == 0, "R12 state codes", code_err, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule